// File: doc/BRIEF.md
# Sequential-Program SPI Flash Controller

This block is the device-side command engine of a serial flash that supports a sequential byte-program mode. It watches a mode-0 SPI bus (active-low chip select, serial clock, serial data in), oversamples it with the system clock, and decodes each frame when chip select returns high. A frame that carries a complete program command produces one single-byte program request toward a memory array. The request travels on a valid/ready channel, and the array reports a long write through a busy input.

The sequential mode lets a host program consecutive bytes without resending the address. The first program frame carries the opcode, a 24-bit address and one data byte. Each later frame carries only the opcode and a data byte, and the target comes from an internal counter that advances by one after every accepted byte. The mode needs the write-enable latch to be set beforehand. A write-disable command or a reset leaves the mode, and the next program frame must again carry an address.

Back-pressure rules for the request channel: once `prog_valid` rises, it stays high with `prog_addr` and `prog_data` unchanged until a cycle in which `prog_ready` is high. While a request waits, or while `arr_busy` is high, the block refuses new program frames. The array owns the rule that programming only clears bits, so the stored byte becomes old AND new.

Top module: `seqprog_flash_ctrl`

## Requirements
- R1: After reset the write-enable latch is 0, sequential mode is off, `prog_valid` and `spi_so_oe` are low and a status read returns 0x00. A two-byte program frame sent after WREN that follows a reset is refused, because the default mode is not sequential.
- R2: A frame made of exactly the byte 0x06 (WREN) sets the write-enable latch, reported in status bit 1.
- R3: After opcode 0x05, every following byte shifts the status byte out on `spi_so`, MSB first. `spi_so_oe` is high only during those bytes, and it stays low during program frames and once chip select is high.
- R4: With the latch set and the mode off, a frame of opcode 0xAD or 0xAF followed by three address bytes (MSB first) and one data byte issues one request to that address with that data. The frame also enters sequential mode, reported in status bit 2.
- R5: In sequential mode, a frame of opcode 0xAD or 0xAF plus one data byte issues a request to the previous address plus one, wrapping from 0xFFFFFF to 0x000000.
- R6: With the latch clear, a program frame issues no request and leaves the mode off.
- R7: A frame whose bit count is not a multiple of eight, or whose byte count does not match the current mode, is discarded and leaves the counter unchanged.
- R8: Status bit 0 (BUSY) is 1 while a request waits or `arr_busy` is high. A program frame ending in that time is ignored, and the counter does not move.
- R9: A frame made of exactly the byte 0x04 (WRDI) clears the latch and leaves sequential mode, so the next program frame needs three address bytes again.
- R10: While `prog_valid` is high and `prog_ready` is low, `prog_valid`, `prog_addr` and `prog_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the SPI lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_si | input | 1 | SPI serial data in, MSB first |
| spi_so | output | 1 | SPI serial data out (status) |
| spi_so_oe | output | 1 | Output enable for `spi_so`; low means high impedance |
| prog_valid | output | 1 | Program request valid |
| prog_ready | input | 1 | Array accepts the request |
| prog_addr | output | 24 | Byte address to program |
| prog_data | output | 8 | Byte value to program |
| arr_busy | input | 1 | Array is still writing |

## Verification
The hardest condition to reach from the ports is a program frame that arrives while an earlier request is still unaccepted or while the array reports busy. The refusal must leave the counter untouched, and only a later frame shows that. The bench holds `prog_ready` low and then raises `arr_busy` around complete frames, then sends a clean frame and checks that it targets the next consecutive address. Address wrap is reached by an entry frame at 0xFFFFFF. Partial frames are made by clocking stray bits after a valid data byte.

// File: rtl/seqprog_pkg.sv
package seqprog_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_SEQ_A = 8'hAD;
  localparam logic [7:0] OP_SEQ_B = 8'hAF;
  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_SEQ  = 2;
endpackage

// File: rtl/seqprog_sync.sv
module seqprog_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/seqprog_rx.sv
module seqprog_rx #(
  parameter int ADDR_W = 24,
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              si_s,
  output logic              frame_end,
  output logic              sck_fall,
  output logic [2:0]        bit_cnt,
  output logic [CNT_W-1:0]  nbytes,
  output logic [7:0]        op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [7:0]        last_q
);
  localparam int ADDR_BYTES = ADDR_W / 8;

  logic       sck_prev, cs_prev;
  logic       sck_rise, frame_start;
  logic [6:0] sh;
  logic [7:0] full;

  assign sck_rise    = !cs_n_s && sck_s && !sck_prev;
  assign sck_fall    = !cs_n_s && !sck_s && sck_prev;
  assign frame_end   = cs_n_s && !cs_prev;
  assign frame_start = !cs_n_s && cs_prev;
  assign full        = {sh, si_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      cs_prev  <= 1'b1;
      sh       <= '0;
      bit_cnt  <= '0;
      nbytes   <= '0;
      op_q     <= '0;
      addr_q   <= '0;
      last_q   <= '0;
    end else begin
      sck_prev <= sck_s;
      cs_prev  <= cs_n_s;
      if (frame_start || frame_end) begin
        bit_cnt <= '0;
        nbytes  <= '0;
      end else if (sck_rise) begin
        sh      <= full[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (nbytes != '1) nbytes <= nbytes + 1'b1;
          last_q <= full;
          if (nbytes == '0) op_q <= full;
          else if (int'(nbytes) <= ADDR_BYTES) addr_q <= {addr_q[ADDR_W-9:0], full};
        end
      end
    end
  end
endmodule

// File: rtl/seqprog_engine.sv
module seqprog_engine
  import seqprog_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W = 3,
  parameter int FIRST_LEN = 5,
  parameter int NEXT_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic [2:0]        bit_cnt,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic [7:0]        op,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [7:0]        data_in,
  input  logic              arr_busy,
  input  logic              prog_ready,
  output logic              prog_valid,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              wel,
  output logic              seq,
  output logic [ADDR_W-1:0] cnt,
  output logic [7:0]        status
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic              busy, whole, is_seq_op, ok_frame, start_first, start_next, single;
  logic [ADDR_W-1:0] tgt;

  assign busy        = prog_valid || arr_busy;
  assign whole       = (bit_cnt == 3'd0);
  assign ok_frame    = frame_end && whole;
  assign is_seq_op   = (op == OP_SEQ_A) || (op == OP_SEQ_B);
  assign start_first = ok_frame && is_seq_op && wel && !busy && !seq &&
                       (nbytes == CNT_W'(FIRST_LEN));
  assign start_next  = ok_frame && is_seq_op && wel && !busy && seq &&
                       (nbytes == CNT_W'(NEXT_LEN));
  assign single      = ok_frame && (nbytes == CNT_W'(1));
  assign tgt         = seq ? cnt : addr_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_valid <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
      wel        <= 1'b0;
      seq        <= 1'b0;
      cnt        <= '0;
    end else begin
      if (prog_valid && prog_ready) prog_valid <= 1'b0;
      if (start_first || start_next) begin
        prog_valid <= 1'b1;
        prog_addr  <= tgt;
        prog_data  <= data_in;
        cnt        <= tgt + ONE;
        seq        <= 1'b1;
      end
      if (single && op == OP_WREN) wel <= 1'b1;
      if (single && op == OP_WRDI) begin
        wel <= 1'b0;
        seq <= 1'b0;
      end
    end
  end

  always_comb begin
    status          = '0;
    status[ST_BUSY] = busy;
    status[ST_WEL]  = wel;
    status[ST_SEQ]  = seq;
  end
endmodule

// File: rtl/seqprog_so.sv
module seqprog_so
  import seqprog_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_s,
  input  logic             sck_fall,
  input  logic [2:0]       bit_cnt,
  input  logic [CNT_W-1:0] nbytes,
  input  logic [7:0]       op,
  input  logic [7:0]       status,
  output logic             so,
  output logic             so_oe
);
  logic [7:0] sh;
  logic       rd_mode;

  assign rd_mode = !cs_n_s && (nbytes != '0) && (op == OP_RDSR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
    end else if (sck_fall && rd_mode) begin
      if (bit_cnt == 3'd0) sh <= status;
      else sh <= {sh[6:0], 1'b0};
    end
  end

  assign so    = sh[7];
  assign so_oe = rd_mode;
endmodule

// File: rtl/seqprog_flash_ctrl.sv
module seqprog_flash_ctrl #(
  parameter int ADDR_W = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_oe,
  output logic              prog_valid,
  input  logic              prog_ready,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  input  logic              arr_busy
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int FIRST_LEN  = ADDR_BYTES + 2;
  localparam int NEXT_LEN   = 2;
  localparam int CNT_W      = $clog2(FIRST_LEN + 2);

  logic [2:0]        lines_s;
  logic              frame_end, sck_fall;
  logic [2:0]        bit_cnt;
  logic [CNT_W-1:0]  nbytes;
  logic [7:0]        op_q, last_q, status;
  logic [ADDR_W-1:0] addr_q, cnt_q;
  logic              wel_q, seq_q;

  seqprog_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sck, spi_si}), .q(lines_s)
  );

  seqprog_rx #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(lines_s[2]), .sck_s(lines_s[1]), .si_s(lines_s[0]),
    .frame_end(frame_end), .sck_fall(sck_fall), .bit_cnt(bit_cnt),
    .nbytes(nbytes), .op_q(op_q), .addr_q(addr_q), .last_q(last_q)
  );

  seqprog_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FIRST_LEN(FIRST_LEN),
                   .NEXT_LEN(NEXT_LEN)) u_eng (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .bit_cnt(bit_cnt),
    .nbytes(nbytes), .op(op_q), .addr_in(addr_q), .data_in(last_q),
    .arr_busy(arr_busy), .prog_ready(prog_ready), .prog_valid(prog_valid),
    .prog_addr(prog_addr), .prog_data(prog_data), .wel(wel_q), .seq(seq_q),
    .cnt(cnt_q), .status(status)
  );

  seqprog_so #(.CNT_W(CNT_W)) u_so (
    .clk(clk), .rst_n(rst_n), .cs_n_s(lines_s[2]), .sck_fall(sck_fall),
    .bit_cnt(bit_cnt), .nbytes(nbytes), .op(op_q), .status(status),
    .so(spi_so), .so_oe(spi_so_oe)
  );
endmodule

// File: rtl/seqprog_chk.sv
module seqprog_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_valid,
  input logic              prog_ready,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [7:0]        prog_data,
  input logic              arr_busy,
  input logic              wel,
  input logic              seq,
  input logic [ADDR_W-1:0] cnt
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid && !prog_ready |=> prog_valid && $stable(prog_addr) && $stable(prog_data));

  p_mode_needs_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq |-> wel);

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_busy |=> !$rose(prog_valid));

  p_next_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_valid) |-> (cnt == prog_addr + ONE));

  p_latch_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_valid) |-> $past(wel));
endmodule

bind seqprog_flash_ctrl seqprog_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_valid(prog_valid), .prog_ready(prog_ready),
  .prog_addr(prog_addr), .prog_data(prog_data), .arr_busy(arr_busy),
  .wel(wel_q), .seq(seq_q), .cnt(cnt_q)
);

// File: tb/seqprog_flash_ctrl_tb.sv
module seqprog_flash_ctrl_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_si = 1'b0;
  logic spi_so, spi_so_oe, prog_valid;
  logic prog_ready = 1'b1, arr_busy = 1'b0;
  logic [23:0] prog_addr;
  logic [7:0]  prog_data;

  seqprog_flash_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_si(spi_si), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
    .prog_valid(prog_valid), .prog_ready(prog_ready), .prog_addr(prog_addr),
    .prog_data(prog_data), .arr_busy(arr_busy)
  );

  int total = 0, bad = 0, cyc = 0, req_cnt = 0;
  bit done = 0;
  logic [23:0] last_addr;
  logic [7:0]  last_data;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && prog_valid && prog_ready) begin
      req_cnt   <= req_cnt + 1;
      last_addr <= prog_addr;
      last_data <= prog_data;
    end
  end

  typedef struct packed {
    logic [3:0]  rq;
    logic [7:0]  op;
    logic [2:0]  nb;
    logic [23:0] addr;
    logic [7:0]  data;
    logic        exp;
    logic [23:0] eaddr;
  } vec_t;

  localparam vec_t VEC [0:12] = '{
    '{4'd2, 8'h06, 3'd1, 24'h000000, 8'h00, 1'b0, 24'h000000},
    '{4'd4, 8'hAD, 3'd5, 24'h000100, 8'h5A, 1'b1, 24'h000100},
    '{4'd5, 8'hAF, 3'd2, 24'h000000, 8'h3C, 1'b1, 24'h000101},
    '{4'd5, 8'hAD, 3'd2, 24'h000000, 8'h11, 1'b1, 24'h000102},
    '{4'd7, 8'hAD, 3'd5, 24'h000500, 8'h22, 1'b0, 24'h000000},
    '{4'd5, 8'hAF, 3'd2, 24'h000000, 8'h33, 1'b1, 24'h000103},
    '{4'd9, 8'h04, 3'd1, 24'h000000, 8'h00, 1'b0, 24'h000000},
    '{4'd6, 8'hAD, 3'd2, 24'h000000, 8'h44, 1'b0, 24'h000000},
    '{4'd2, 8'h06, 3'd1, 24'h000000, 8'h00, 1'b0, 24'h000000},
    '{4'd9, 8'hAD, 3'd2, 24'h000000, 8'h55, 1'b0, 24'h000000},
    '{4'd4, 8'hAF, 3'd5, 24'hFFFFFF, 8'h77, 1'b1, 24'hFFFFFF},
    '{4'd5, 8'hAD, 3'd2, 24'h000000, 8'h88, 1'b1, 24'h000000},
    '{4'd5, 8'hAD, 3'd2, 24'h000000, 8'h99, 1'b1, 24'h000001}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all, output logic oe_any);
    rx = '0; oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      spi_si = tx[i];
      tick(HALF);
      rx[i]  = spi_so;
      oe_all = oe_all & spi_so_oe;
      oe_any = oe_any | spi_so_oe;
      spi_sck = 1'b1;
      tick(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] op, input int nb, input logic [23:0] addr,
                       input logic [7:0] data, input int extra, output logic oe_seen);
    logic [7:0] rx; logic a, o;
    oe_seen = 1'b0;
    spi_cs_n = 1'b0; tick(HALF);
    xfer(op, rx, a, o); oe_seen |= o;
    if (nb >= 5) for (int k = 2; k >= 0; k--) begin
      xfer(addr[k*8 +: 8], rx, a, o); oe_seen |= o;
    end
    if (nb >= 2) begin xfer(data, rx, a, o); oe_seen |= o; end
    for (int k = 0; k < extra; k++) begin
      spi_si = k[0]; tick(HALF); spi_sck = 1'b1; tick(HALF); spi_sck = 1'b0;
    end
    tick(HALF); spi_cs_n = 1'b1; tick(16);
  endtask

  task automatic rdsr(output logic [7:0] st, output logic oe_ok);
    logic [7:0] rx; logic a, o;
    spi_cs_n = 1'b0; tick(HALF);
    xfer(8'h05, rx, a, o);
    xfer(8'h00, st, a, o);
    oe_ok = a;
    tick(HALF); spi_cs_n = 1'b1; tick(16);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    summary();
  end

  initial begin
    logic [7:0] st; logic oe_ok, oe_seen; int prev;
    tick(5); rst_n = 1'b1; tick(5);
    // R1 reset state
    chk(prog_valid == 1'b0, "R1 prog_valid after reset", prog_valid, 0);
    chk(spi_so_oe == 1'b0, "R1 so_oe after reset", spi_so_oe, 0);
    rdsr(st, oe_ok);
    chk(st == 8'h00, "R1 status after reset", st, 8'h00);
    chk(oe_ok == 1'b1, "R3 so_oe during status byte", oe_ok, 1);
    chk(spi_so_oe == 1'b0, "R3 so_oe after cs high", spi_so_oe, 0);

    for (int i = 0; i < 13; i++) begin
      prev = req_cnt;
      frame(VEC[i].op, int'(VEC[i].nb), VEC[i].addr, VEC[i].data, 0, oe_seen);
      chk(req_cnt == prev + int'(VEC[i].exp), $sformatf("R%0d vec%0d request count", VEC[i].rq, i),
          req_cnt, prev + int'(VEC[i].exp));
      if (VEC[i].exp) begin
        chk(last_addr == VEC[i].eaddr, $sformatf("R%0d vec%0d address", VEC[i].rq, i), last_addr, VEC[i].eaddr);
        chk(last_data == VEC[i].data, $sformatf("R%0d vec%0d data", VEC[i].rq, i), last_data, VEC[i].data);
      end
      chk(oe_seen == 1'b0, $sformatf("R3 vec%0d SO quiet", i), oe_seen, 0);
      if (i == 0) begin
        rdsr(st, oe_ok);
        chk(st == 8'h02, "R2 latch in status bit 1", st, 8'h02);
      end
    end

    rdsr(st, oe_ok);
    chk(st == 8'h06, "R4 sequential mode in status bit 2", st, 8'h06);

    // R7 partial frame with stray bits
    prev = req_cnt;
    frame(8'hAD, 2, 24'h0, 8'hE1, 3, oe_seen);
    chk(req_cnt == prev, "R7 partial frame discarded", req_cnt, prev);
    frame(8'hAD, 2, 24'h0, 8'hE2, 0, oe_seen);
    chk(last_addr == 24'h000002, "R7 counter unchanged by partial", last_addr, 24'h000002);

    // R8 / R10 back-pressure and busy
    prog_ready = 1'b0;
    prev = req_cnt;
    frame(8'hAD, 2, 24'h0, 8'hA1, 0, oe_seen);
    chk(prog_valid == 1'b1 && prog_addr == 24'h000003, "R10 request pending", prog_addr, 24'h000003);
    tick(20);
    chk(prog_valid == 1'b1 && prog_data == 8'hA1, "R10 request held", prog_data, 8'hA1);
    rdsr(st, oe_ok);
    chk(st == 8'h07, "R8 busy bit while pending", st, 8'h07);
    frame(8'hAD, 2, 24'h0, 8'hB2, 0, oe_seen);
    prog_ready = 1'b1; tick(4);
    chk(req_cnt == prev + 1 && last_data == 8'hA1, "R8 frame during pending ignored", last_data, 8'hA1);
    tick(4);
    chk(req_cnt == prev + 1, "R8 single request after release", req_cnt, prev + 1);
    arr_busy = 1'b1;
    rdsr(st, oe_ok);
    chk(st == 8'h07, "R8 busy bit from array", st, 8'h07);
    frame(8'hAD, 2, 24'h0, 8'hC3, 0, oe_seen);
    chk(req_cnt == prev + 1, "R8 frame during array busy ignored", req_cnt, prev + 1);
    arr_busy = 1'b0;
    frame(8'hAD, 2, 24'h0, 8'hD4, 0, oe_seen);
    chk(last_addr == 24'h000004 && last_data == 8'hD4, "R8 counter untouched by ignored frames",
        last_addr, 24'h000004);

    // R9 / R6 exit then refusal without latch
    frame(8'h04, 1, 24'h0, 8'h0, 0, oe_seen);
    rdsr(st, oe_ok);
    chk(st == 8'h00, "R9 WRDI clears latch and mode", st, 8'h00);
    prev = req_cnt;
    frame(8'hAD, 5, 24'h000010, 8'h66, 0, oe_seen);
    chk(req_cnt == prev, "R6 entry refused without latch", req_cnt, prev);
    rdsr(st, oe_ok);
    chk(st == 8'h00, "R6 mode stays off", st, 8'h00);

    // R1 reset during sequential mode
    frame(8'h06, 1, 24'h0, 8'h0, 0, oe_seen);
    frame(8'hAF, 5, 24'h000020, 8'h12, 0, oe_seen);
    chk(last_addr == 24'h000020, "R4 entry at new address", last_addr, 24'h000020);
    rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
    rdsr(st, oe_ok);
    chk(st == 8'h00, "R1 status after mid-run reset", st, 8'h00);
    frame(8'h06, 1, 24'h0, 8'h0, 0, oe_seen);
    prev = req_cnt;
    frame(8'hAD, 2, 24'h0, 8'h34, 0, oe_seen);
    chk(req_cnt == prev, "R1 default mode after reset needs address", req_cnt, prev);

    summary();
  end
endmodule